// File: doc/BRIEF.md
# Reference-Window Frequency Lock Detector

This block decides when a two-loop clock recovery circuit has finished coarse frequency acquisition and may hand over to fine phase tracking. On every rising edge of the reference clock it samples two recovered clocks that sit a quarter period apart, at 0 degrees and at 90 degrees. It then asks whether the reference edge landed inside the 90-degree window between them. If it did, the recovered clock is running close to the reference rate. If the edge keeps landing in that window for an unbroken run of reference periods, the two clocks cannot be drifting apart by more than a small fraction of a period.

A saturating run counter measures that run. With a counter of `CNT_W` bits the flag needs `2**CNT_W` consecutive in-window periods. The frequency resolution is therefore 90/(2**CNT_W * 360) of the rate, which is about ±1.56% at the default width of 4. A wider counter gives a finer resolution at the cost of a longer acquisition.

Both recovered clocks are asynchronous to the reference, so they pass through a two-flop synchroniser before they are judged. Once raised, the lock flag stays set until reset. A loop-select output mirrors it and steers the loop from the frequency-acquisition path to the phase-locking path.

Top module: `phase_window_lock`

## Requirements
- R1: A synchronised sample is in the window only when the 0-degree clock is high and the 90-degree clock is low. The other three combinations (both low, both high, 0-degree low with 90-degree high) are out of the window and never advance the run.
- R2: Each recovered clock passes through two flops clocked by the reference clock. The lock flag rises on the second reference rising edge after the edge that sampled the final in-window value of a qualifying run.
- R3: The lock flag rises only after `2**CNT_W` consecutive in-window samples (16 with `CNT_W` = 4). A run of `2**CNT_W - 1` samples followed by an out-of-window sample does not raise it.
- R4: Any out-of-window sample taken before lock clears the run count to zero. Two runs of 15 in-window samples split by a single out-of-window sample do not raise the flag.
- R5: Once the lock flag is high it stays high for any recovered-clock input until reset.
- R6: The loop-select output equals the lock flag in every cycle: 0 selects the frequency-acquisition loop and 1 selects the phase-locking loop.
- R7: An active-high reset clears the lock flag, the run count and the synchroniser flops. A partial run begun before reset does not carry over to the samples taken after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all state updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| rclk_ph0 | input | 1 | Recovered clock, 0-degree phase (asynchronous) |
| rclk_ph90 | input | 1 | Recovered clock, 90-degree phase (asynchronous) |
| lock_o | output | 1 | Frequency lock flag; sticky until reset |
| loop_sel_o | output | 1 | Loop select: 0 = frequency acquisition, 1 = phase locking |

## Verification
The assertions assume that the recovered-clock inputs, once synchronised, settle to clean levels at each reference edge. They also assume that reset is released only after the synchroniser flops hold their cleared zero value, so the two-edge latency check starts from known history. The stimulus meets both assumptions by driving the recovered-clock levels at the falling edge of the reference clock, so every rising edge sees a settled value. It also holds reset over several reference edges. The recovered clocks are modelled as level patterns per reference period, which covers each of the four sampled combinations, runs that stop one short of the target, broken runs and runs that qualify.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  // Number of in-window samples needed to declare lock for a counter width.
  function automatic int unsigned run_target(input int unsigned cnt_w);
    return 32'd1 << cnt_w;
  endfunction

  // Frequency resolution in parts per million: 90 / (2**w * 360) = 1 / (4 * 2**w).
  function automatic int unsigned resolution_ppm(input int unsigned cnt_w);
    return 32'd1000000 / (32'd4 << cnt_w);
  endfunction

  // Window decode: reference edge lies after the 0-degree rise and before the 90-degree rise.
  function automatic logic in_window(input logic ph0, input logic ph90);
    return ph0 & ~ph90;
  endfunction

endpackage

// File: rtl/pwl_sync.sv
module pwl_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[b];
        stable_q <= meta_q;
      end
    end

    assign sync_o[b] = stable_q;
  end

endmodule

// File: rtl/pwl_run_counter.sv
module pwl_run_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic lock_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  logic [CNT_W-1:0] run_q;
  logic             lock_q;
  logic             run_done;

  // The current sample completes the run when the count already holds 2**CNT_W - 1 hits.
  assign run_done = hit_i && (run_q == CNT_FULL);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (!hit_i) begin
        run_q <= '0;
      end else if (run_q != CNT_FULL) begin
        run_q <= run_q + 1'b1;
      end
      if (run_done) begin
        lock_q <= 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  // R4
  miss_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && !hit_i) |=> (run_q == '0));

  // R3
  hit_advances_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && hit_i && run_q != CNT_FULL) |=> (run_q == $past(run_q) + 1'b1));

  // R3
  lock_needs_full_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> ($past(run_q) == CNT_FULL && $past(hit_i)));

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

endmodule

// File: rtl/phase_window_lock.sv
module phase_window_lock #(
  parameter int CNT_W = 4
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic rclk_ph0,
  input  logic rclk_ph90,
  output logic lock_o,
  output logic loop_sel_o
);

  import pwl_pkg::*;

  localparam int unsigned RUN_LEN  = run_target(CNT_W);
  localparam int unsigned RES_PPM  = resolution_ppm(CNT_W);

  logic [1:0] phase_sync;
  logic       win_hit;
  logic       lock_flag;

  pwl_sync #(.WIDTH(2)) u_sync (
    .clk     (ref_clk),
    .rst     (rst),
    .async_i ({rclk_ph90, rclk_ph0}),
    .sync_o  (phase_sync)
  );

  assign win_hit = in_window(phase_sync[0], phase_sync[1]);

  pwl_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk    (ref_clk),
    .rst    (rst),
    .hit_i  (win_hit),
    .lock_o (lock_flag)
  );

  assign lock_o     = lock_flag;
  assign loop_sel_o = lock_flag;

  initial begin
    if (RUN_LEN < 2 || RES_PPM == 0) begin
      $display("phase_window_lock: CNT_W=%0d out of useful range", CNT_W);
    end
  end

  // R2
  sync_latency_chk: assert property (@(posedge ref_clk) disable iff (rst)
    win_hit |-> ($past(rclk_ph0, 2) && !$past(rclk_ph90, 2)));

  // R1
  window_shape_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!$past(rclk_ph0, 2) || $past(rclk_ph90, 2)) |-> !win_hit);

endmodule

// File: tb/phase_window_lock_bench.sv
module phase_window_lock_bench;

  localparam int W = 4;

  logic ref_clk = 1'b0;
  logic rst;
  logic ph0;
  logic ph90;
  logic lock;
  logic sel;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 ref_clk = ~ref_clk;

  phase_window_lock #(.CNT_W(W)) u_phase_window_lock (
    .ref_clk    (ref_clk),
    .rst        (rst),
    .rclk_ph0   (ph0),
    .rclk_ph90  (ph90),
    .lock_o     (lock),
    .loop_sel_o (sel)
  );

  // Behavioural reference: a queue holds the two samples still in flight.
  logic [1:0] pipe[$];
  int         m_run  = 0;
  bit         m_lock = 1'b0;

  always @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      pipe.delete();
      pipe.push_back(2'b00);
      pipe.push_back(2'b00);
      m_run  = 0;
      m_lock = 1'b0;
    end else begin
      logic [1:0] s;
      s = pipe.pop_front();
      if (!m_lock) begin
        if (s == 2'b01) begin
          m_run++;
          if (m_run >= (1 << W)) m_lock = 1'b1;
        end else begin
          m_run = 0;
        end
      end
      pipe.push_back({ph90, ph0});
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle compare against the model on every falling edge.
  always @(negedge ref_clk) begin
    if (!rst) begin
      check(lock == m_lock, "R3 model lock", lock, m_lock);
      check(sel == lock, "R6 loop select", sel, lock);
    end
  end

  task automatic drive(input logic p0, input logic p90, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      ph0  = p0;
      ph90 = p90;
    end
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst = 1'b1;
    repeat (3) @(negedge ref_clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst  = 1'b1;
    ph0  = 1'b0;
    ph90 = 1'b0;
    repeat (3) @(negedge ref_clk);
    check(lock == 1'b0, "R7 lock in reset", lock, 0);
    check(sel == 1'b0, "R6 select in reset", sel, 0);
    rst = 1'b0;

    // R1: every out-of-window combination, long runs each
    drive(1'b0, 1'b0, 20);
    drive(1'b1, 1'b1, 20);
    drive(1'b0, 1'b1, 20);
    drive(1'b0, 1'b0, 3);
    check(lock == 1'b0, "R1 out-of-window combos", lock, 0);

    // R3: one short of the target
    drive(1'b1, 1'b0, (1 << W) - 1);
    drive(1'b0, 1'b0, 4);
    check(lock == 1'b0, "R3 run of 15", lock, 0);

    // R4: broken run, pattern ph90 high / ph0 low in the middle
    drive(1'b1, 1'b0, (1 << W) - 1);
    drive(1'b0, 1'b1, 1);
    drive(1'b1, 1'b0, (1 << W) - 1);
    drive(1'b1, 1'b1, 4);
    check(lock == 1'b0, "R4 broken run", lock, 0);

    // R2/R3: exact run length and two-edge latency
    drive(1'b1, 1'b0, 1 << W);
    @(negedge ref_clk);
    ph0 = 1'b0;
    check(lock == 1'b0, "R2 latency edge+0", lock, 0);
    @(negedge ref_clk);
    check(lock == 1'b0, "R2 latency edge+1", lock, 0);
    @(negedge ref_clk);
    check(lock == 1'b1, "R2 latency edge+2", lock, 1);
    check(sel == 1'b1, "R6 phase loop selected", sel, 1);

    // R5: sticky under every input
    drive(1'b0, 1'b0, 10);
    drive(1'b0, 1'b1, 10);
    drive(1'b1, 1'b1, 10);
    check(lock == 1'b1, "R5 sticky lock", lock, 1);

    // R7: reset clears lock and partial runs
    do_reset();
    check(lock == 1'b0, "R7 lock cleared", lock, 0);
    drive(1'b1, 1'b0, 10);
    do_reset();
    drive(1'b1, 1'b0, 10);
    drive(1'b0, 1'b0, 4);
    check(lock == 1'b0, "R7 partial run forgotten", lock, 0);

    // R3: a longer in-window run still locks
    drive(1'b1, 1'b0, 40);
    drive(1'b0, 1'b0, 3);
    check(lock == 1'b1, "R3 long run locks", lock, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule